// File: doc/BRIEF.md
# I2C Passive Bus Monitor

This block listens to an I2C bus through already synchronized SCL and SDA inputs and records every byte that travels on it, no matter which device drives it. Each captured byte is stored together with three tags: it was the first byte after a Start from an idle bus, it was the first byte after a repeated Start, or no receiver acknowledged it. The block also tracks whether a transfer is in progress on the bus, and it raises a sticky flag each time the bus returns to idle.

Software reads captured bytes through a small register port. A ready flag tells it that a byte is waiting, and reading the byte clears that flag. Two policies handle a slow reader. In reporting mode the monitor never touches the bus, and a byte that arrives before the previous one was read sets a sticky overrun flag. In lossless mode the monitor requests SCL to be held low until the waiting byte is read. Its only bus output is an open-drain pull-low request for SCL. One interrupt line combines the ready, overrun and idle flags, and each of these flags has its own enable bit.

Top module: `i2c_snoop`

## Requirements
- R1: After reset the config (address 0), status (address 1) and receive word (address 2) all read 0, and sclPullLow and irq are 0.
- R2: While the bus is active, data bits are sampled on SCL rising edges with the MSB first. The rising edge after the eighth data bit commits the byte to bits [7:0] of the receive word, and the SDA level on that ninth edge goes to bit 10 (1 = not acknowledged, 0 = acknowledged).
- R3: Bit 8 of the receive word is 1 only on the first byte after a Start seen while the bus was inactive. Bit 9 is 1 only on the first byte after a Start seen while the bus was active. All later bytes carry 0 in both bits.
- R4: Status bit 0 (ready) is set when a byte is committed and is cleared by a read of address 2.
- R5: When stretching is off, a byte committed while ready is still set sets status bit 1 (overrun) and replaces the stored byte. Overrun is cleared only by writing 1 to bit 1 of address 1. Writing 0 to that bit leaves it set.
- R6: With config bit 1 (stretch) at 0, sclPullLow is never asserted.
- R7: With stretch at 1, sclPullLow is asserted while an unread byte is waiting and SCL is low. It is released after the byte is read, and no overrun occurs.
- R8: Status bit 2 (active) is set by a Start (SDA falling while SCL is high) and cleared by a Stop (SDA rising while SCL is high).
- R9: Status bit 3 (idle) is set on every transition from active to inactive and is cleared by writing 1 to bit 3 of address 1.
- R10: Clearing config bit 0 (enable) resets all status flags, the capture state and the receive word. The config bits keep their written values.
- R11: irq is (ready AND config bit 2) OR (overrun AND config bit 3) OR (idle AND config bit 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Synchronized SCL level |
| sdaIn | input | 1 | Synchronized SDA level |
| rdEn | input | 1 | Read strobe; a read of address 2 consumes the byte |
| wrEn | input | 1 | Write strobe |
| addr | input | 2 | Register select: 0 config, 1 status, 2 receive word |
| wrData | input | 5 | Write data (config bits, or write-1-to-clear status bits) |
| rdData | output | BYTE_W+3 | Combinational read data for addr |
| sclPullLow | output | 1 | Request to pull SCL low (open drain) |
| irq | output | 1 | Combined, gated interrupt |

## Verification
The assertions assume that SCL and SDA are clean, synchronized levels: each level holds for at least one clock, and SDA changes while SCL is high only to form a Start or a Stop. They also assume that a master honours the SCL pull-low request by waiting until SCL actually reads high. The bench bus model drives SDA only while its own SCL is low, except inside Start and Stop sequences. It models SCL as a wired-AND with the pull-low request, and after releasing SCL it waits until the line reads high, so every transfer stays inside these assumptions.

// File: rtl/snoop_pkg.sv
package snoop_pkg;

  // control-to-datapath strobes
  typedef struct packed {
    logic flush;
    logic noteStart;
    logic noteRestart;
    logic shift;
    logic commit;
  } strobe_t;

  // config register layout, LSB first: enable, stretch, ieRdy, ieOvr, ieIdle
  typedef struct packed {
    logic ieIdle;
    logic ieOvr;
    logic ieRdy;
    logic stretch;
    logic enable;
  } cfg_t;

  // status layout, LSB first: ready, overrun, active, idle
  typedef struct packed {
    logic idle;
    logic active;
    logic overrun;
    logic ready;
  } stat_t;

  localparam int CFG_W  = $bits(cfg_t);
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CFG  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_RX   = 2'd2;

  localparam int STAT_OVR_BIT  = 1;
  localparam int STAT_IDLE_BIT = 3;

endpackage

// File: rtl/snoop_datapath.sv
module snoop_datapath
  import snoop_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sdaIn,
  input  strobe_t              stb,
  input  cfg_t                 cfg,
  input  stat_t                stat,
  input  logic [ADDR_W-1:0]    addr,
  output logic [BYTE_W+2:0]    rdData
);

  localparam int RX_W = BYTE_W + 3;

  logic [BYTE_W-1:0] shiftReg;
  logic              pendStart;
  logic              pendRestart;
  logic [BYTE_W-1:0] capByte;
  logic              capStart;
  logic              capRestart;
  logic              capNack;
  logic [RX_W-1:0]   rxWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg    <= '0;
      pendStart   <= 1'b0;
      pendRestart <= 1'b0;
      capByte     <= '0;
      capStart    <= 1'b0;
      capRestart  <= 1'b0;
      capNack     <= 1'b0;
    end else if (stb.flush) begin
      shiftReg    <= '0;
      pendStart   <= 1'b0;
      pendRestart <= 1'b0;
      capByte     <= '0;
      capStart    <= 1'b0;
      capRestart  <= 1'b0;
      capNack     <= 1'b0;
    end else begin
      if (stb.noteStart) begin
        pendStart   <= 1'b1;
        pendRestart <= 1'b0;
      end else if (stb.noteRestart) begin
        pendStart   <= 1'b0;
        pendRestart <= 1'b1;
      end else if (stb.commit) begin
        pendStart   <= 1'b0;
        pendRestart <= 1'b0;
      end
      if (stb.shift) begin
        shiftReg <= {shiftReg[BYTE_W-2:0], sdaIn};
      end
      if (stb.commit) begin
        capByte    <= shiftReg;
        capNack    <= sdaIn;
        capStart   <= pendStart;
        capRestart <= pendRestart;
      end
    end
  end

  assign rxWord = {capNack, capRestart, capStart, capByte};

  always_comb begin
    case (addr)
      ADDR_CFG:  rdData = RX_W'(cfg);
      ADDR_STAT: rdData = RX_W'(stat);
      ADDR_RX:   rdData = rxWord;
      default:   rdData = '0;
    endcase
  end

endmodule

// File: rtl/snoop_ctrl.sv
module snoop_ctrl
  import snoop_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CFG_W-1:0]  wrData,
  output strobe_t           stb,
  output cfg_t              cfg,
  output stat_t             stat,
  output logic              sclPullLow,
  output logic              irq
);

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);

  logic             prevScl;
  logic             prevSda;
  logic             sclRise;
  logic             startEv;
  logic             stopEv;
  logic             run;
  logic             cfgWr;
  logic             statWr;
  logic             rxRd;
  logic             readyKeep;
  logic [CNT_W-1:0] bitCnt;
  logic             readyQ;
  logic             ovrQ;
  logic             activeQ;
  logic             idleQ;
  logic             holdQ;

  // bus event decode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevScl <= 1'b1;
      prevSda <= 1'b1;
    end else begin
      prevScl <= sclIn;
      prevSda <= sdaIn;
    end
  end

  assign sclRise = sclIn & ~prevScl;
  assign startEv = prevScl & sclIn & prevSda & ~sdaIn;
  assign stopEv  = prevScl & sclIn & ~prevSda & sdaIn;

  // register access decode
  assign cfgWr     = wrEn & (addr == ADDR_CFG);
  assign statWr    = wrEn & (addr == ADDR_STAT);
  assign rxRd      = rdEn & (addr == ADDR_RX);
  assign run       = cfg.enable;
  assign readyKeep = readyQ & ~rxRd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfg <= '0;
    else if (cfgWr) cfg <= cfg_t'(wrData);
  end

  // strobes to datapath
  always_comb begin
    stb             = '0;
    stb.flush       = ~run;
    stb.noteStart   = run & startEv & ~activeQ;
    stb.noteRestart = run & startEv & activeQ;
    stb.shift       = run & activeQ & sclRise & (bitCnt < ACK_SLOT);
    stb.commit      = run & activeQ & sclRise & (bitCnt == ACK_SLOT);
  end

  // bus framing state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      bitCnt  <= '0;
    end else if (!run) begin
      activeQ <= 1'b0;
      bitCnt  <= '0;
    end else begin
      if (startEv)     activeQ <= 1'b1;
      else if (stopEv) activeQ <= 1'b0;

      if (startEv || stopEv || stb.commit) bitCnt <= '0;
      else if (stb.shift)                  bitCnt <= bitCnt + 1'b1;
    end
  end

  // software-facing flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readyQ <= 1'b0;
      ovrQ   <= 1'b0;
      idleQ  <= 1'b0;
      holdQ  <= 1'b0;
    end else if (!run) begin
      readyQ <= 1'b0;
      ovrQ   <= 1'b0;
      idleQ  <= 1'b0;
      holdQ  <= 1'b0;
    end else begin
      if (stb.commit)  readyQ <= 1'b1;
      else if (rxRd)   readyQ <= 1'b0;

      if (stb.commit && readyKeep && !cfg.stretch)  ovrQ <= 1'b1;
      else if (statWr && wrData[STAT_OVR_BIT])      ovrQ <= 1'b0;

      if (stopEv && activeQ)                        idleQ <= 1'b1;
      else if (statWr && wrData[STAT_IDLE_BIT])     idleQ <= 1'b0;

      holdQ <= cfg.stretch & readyKeep & ~sclIn;
    end
  end

  assign stat       = '{idle: idleQ, active: activeQ, overrun: ovrQ, ready: readyQ};
  assign sclPullLow = holdQ;
  assign irq        = |({idleQ, ovrQ, readyQ} & {cfg.ieIdle, cfg.ieOvr, cfg.ieRdy});

endmodule

// File: rtl/i2c_snoop.sv
module i2c_snoop
  import snoop_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CFG_W-1:0]  wrData,
  output logic [BYTE_W+2:0] rdData,
  output logic              sclPullLow,
  output logic              irq
);

  strobe_t stb;
  cfg_t    cfg;
  stat_t   stat;

  snoop_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclIn),
    .sdaIn      (sdaIn),
    .rdEn       (rdEn),
    .wrEn       (wrEn),
    .addr       (addr),
    .wrData     (wrData),
    .stb        (stb),
    .cfg        (cfg),
    .stat       (stat),
    .sclPullLow (sclPullLow),
    .irq        (irq)
  );

  snoop_datapath #(.BYTE_W(BYTE_W)) u_data (
    .clk    (clk),
    .rstN   (rstN),
    .sdaIn  (sdaIn),
    .stb    (stb),
    .cfg    (cfg),
    .stat   (stat),
    .addr   (addr),
    .rdData (rdData)
  );

endmodule

// File: rtl/snoop_checker.sv
module snoop_checker
  import snoop_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              sclIn,
  input logic              sdaIn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input cfg_t              cfg,
  input stat_t             stat,
  input logic              sclPullLow,
  input logic              irq
);

  logic cPrevScl;
  logic cPrevSda;
  logic cStart;
  logic cStop;
  logic cRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cPrevScl <= 1'b1;
      cPrevSda <= 1'b1;
    end else begin
      cPrevScl <= sclIn;
      cPrevSda <= sdaIn;
    end
  end

  assign cStart = cPrevScl & sclIn & cPrevSda & ~sdaIn;
  assign cStop  = cPrevScl & sclIn & ~cPrevSda & sdaIn;
  assign cRise  = sclIn & ~cPrevScl;

  a_r4_read_clears_ready: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == ADDR_RX && !cRise) |=> !stat.ready);

  a_r5_overrun_only_without_stretch: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stat.overrun) |-> !$past(cfg.stretch));

  a_r6_silent_without_stretch: assert property (@(posedge clk) disable iff (!rstN)
    $past(!cfg.stretch) |-> !sclPullLow);

  a_r7_hold_needs_ready: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclPullLow) |-> $past(stat.ready));

  a_r8_start_sets_active: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.enable && cStart) |=> (stat.active || !$past(cfg.enable)));

  a_r8_stop_clears_active: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.enable && cStop) |=> !stat.active);

  a_r9_idle_follows_active: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stat.idle) |-> $past(stat.active));

  a_r10_disable_clears: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.enable |=> (!stat.active && !stat.ready && !stat.overrun && !stat.idle));

  a_r11_irq_needs_flag: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (stat.ready || stat.overrun || stat.idle));

endmodule

bind i2c_snoop snoop_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .sclIn      (sclIn),
  .sdaIn      (sdaIn),
  .rdEn       (rdEn),
  .addr       (addr),
  .cfg        (cfg),
  .stat       (stat),
  .sclPullLow (sclPullLow),
  .irq        (irq)
);

// File: tb/i2c_snoop_bench.sv
module i2c_snoop_bench;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int BYTE_W     = 8;
  localparam int RX_W       = BYTE_W + 3;
  localparam int NVEC       = 6;
  // vector: {kind[1:0], nack, byte}; kind 0 none, 1 start, 2 repeated start
  localparam logic [10:0] VEC [NVEC] = '{
    {2'd1, 1'b0, 8'hA0},
    {2'd0, 1'b0, 8'h55},
    {2'd0, 1'b1, 8'hFF},
    {2'd2, 1'b0, 8'hA1},
    {2'd0, 1'b1, 8'h00},
    {2'd0, 1'b0, 8'h3C}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busScl = 1'b1;
  logic busSda = 1'b1;
  logic rdEn = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [4:0] wrData = 5'd0;
  logic [RX_W-1:0] rdData;
  logic sclPullLow;
  logic irq;
  logic sclIn;
  logic sdaIn;

  int testCount = 0;
  int failCount = 0;
  bit done = 1'b0;
  bit stretchPhase = 1'b0;
  bit badPull = 1'b0;

  assign sclIn = busScl & ~sclPullLow;
  assign sdaIn = busSda;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_snoop #(.BYTE_W(BYTE_W)) u_i2c_snoop (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rdEn(rdEn), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .sclPullLow(sclPullLow), .irq(irq)
  );

  always @(negedge clk) if (!stretchPhase && sclPullLow) badPull = 1'b1;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    testCount++;
    if (got !== exp) begin
      failCount++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regRead(input logic [1:0] a, output logic [RX_W-1:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [4:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitSclHigh();
    for (int t = 0; t < 3000 && !sclIn; t++) @(negedge clk);
  endtask

  task automatic busStart();
    busSda = 1'b1; waitClk(HALF);
    busScl = 1'b1; waitSclHigh(); waitClk(HALF);
    busSda = 1'b0; waitClk(HALF);
    busScl = 1'b0; waitClk(HALF);
  endtask

  task automatic busStop();
    busSda = 1'b0; waitClk(HALF);
    busScl = 1'b1; waitSclHigh(); waitClk(HALF);
    busSda = 1'b1; waitClk(HALF);
  endtask

  task automatic sendBit(input logic b);
    busSda = b; waitClk(HALF);
    busScl = 1'b1; waitSclHigh(); waitClk(HALF);
    busScl = 1'b0; waitClk(HALF);
  endtask

  task automatic sendByte(input logic [7:0] b, input logic nack);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    sendBit(nack);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failCount++;
      testCount++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    logic [RX_W-1:0] d;
    logic [RX_W-1:0] exp;
    waitClk(3);
    rstN = 1'b1;
    waitClk(2);

    // R1 reset state
    regRead(2'd0, d); check("R1 cfg", 32'(d), 0);
    regRead(2'd1, d); check("R1 status", 32'(d), 0);
    regRead(2'd2, d); check("R1 rx", 32'(d), 0);
    check("R1 pull", 32'(sclPullLow), 0);
    check("R1 irq", 32'(irq), 0);

    // R2 R3 R4 vector walk, reporting mode
    regWrite(2'd0, 5'h01);
    for (int v = 0; v < NVEC; v++) begin
      if (VEC[v][10:9] != 2'd0) busStart();
      sendByte(VEC[v][7:0], VEC[v][8]);
      exp = {VEC[v][8], VEC[v][10:9] == 2'd2, VEC[v][10:9] == 2'd1, VEC[v][7:0]};
      regRead(2'd1, d); check("R4 ready+R8 active", 32'(d), 32'h5);
      regRead(2'd2, d); check("R2/R3 rx word", 32'(d), 32'(exp));
      regRead(2'd1, d); check("R4 ready cleared", 32'(d), 32'h4);
    end
    busStop();
    regRead(2'd1, d); check("R8/R9 stop -> idle", 32'(d), 32'h8);
    regWrite(2'd0, 5'h11);
    check("R11 idle irq", 32'(irq), 1);
    regWrite(2'd1, 5'h08);
    regRead(2'd1, d); check("R9 idle w1c", 32'(d), 32'h0);
    check("R11 irq drops", 32'(irq), 0);

    // R5 overrun
    regWrite(2'd0, 5'h01);
    busStart();
    sendByte(8'h11, 1'b0);
    sendByte(8'h22, 1'b1);
    regRead(2'd1, d); check("R5 overrun set", 32'(d), 32'h7);
    regWrite(2'd0, 5'h09);
    check("R11 overrun irq", 32'(irq), 1);
    regRead(2'd2, d); check("R5 newer byte kept", 32'(d), 32'h422);
    regWrite(2'd1, 5'h00);
    regRead(2'd1, d); check("R5 write 0 ignored", 32'(d), 32'h6);
    regWrite(2'd0, 5'h05);
    check("R11 gated off", 32'(irq), 0);
    regWrite(2'd1, 5'h02);
    regRead(2'd1, d); check("R5 w1c", 32'(d), 32'h4);
    busStop();
    regWrite(2'd1, 5'h08);
    check("R6 no pull in reporting mode", 32'(badPull), 0);

    // R7 stretching
    stretchPhase = 1'b1;
    regWrite(2'd0, 5'h03);
    busStart();
    sendByte(8'h5A, 1'b0);
    fork
      sendByte(8'hC3, 1'b1);
      begin
        waitClk(60);
        check("R7 pull held", 32'(sclPullLow), 1);
        check("R7 scl low", 32'(sclIn), 0);
        regRead(2'd2, d); check("R7 first byte", 32'(d), 32'h15A);
      end
    join
    regRead(2'd2, d); check("R7 second byte", 32'(d), 32'h4C3);
    waitClk(3);
    check("R7 released", 32'(sclPullLow), 0);
    regRead(2'd1, d); check("R7 no overrun", 32'(d), 32'h4);
    busStop();
    regWrite(2'd1, 5'h08);
    stretchPhase = 1'b0;

    // R10 disable
    regWrite(2'd0, 5'h01);
    busStart();
    sendByte(8'h77, 1'b0);
    regRead(2'd1, d); check("R10 pre-disable", 32'(d), 32'h5);
    regWrite(2'd0, 5'h1C);
    regRead(2'd1, d); check("R10 status cleared", 32'(d), 32'h0);
    regRead(2'd2, d); check("R10 rx cleared", 32'(d), 32'h0);
    regRead(2'd0, d); check("R10 cfg kept", 32'(d), 32'h1C);
    regWrite(2'd0, 5'h01);
    busStop();
    regRead(2'd1, d); check("R10 no idle when inactive", 32'(d), 32'h0);
    busStart();
    regRead(2'd1, d); check("R8 active after start", 32'(d), 32'h4);
    busStop();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule